// File: doc/BRIEF.md
# Ones' Complement Checksum Compressor

This block takes thirty-two 16-bit words presented together and returns their ones' complement sum, the quantity that IP and TCP checksums are built from. Forming the final checksum by inverting the result, and parsing packets to gather the words, are left to the logic around it.

The words are not added one after another or through a tree of word-wide adders. The block treats every bit of every word as a weighted dot in its column and reduces all columns at once with layers of 3:2 full-adder compressors (carry-save form). This is the same as counting the ones in each of the 16 columns and weighting each count by its bit position. After compression, a single carry-propagate adder produces a 21-bit binary total. Two end-around folds then return the bits above bit 15 to the bottom of the word.

A parameter places an optional register between the compressor and the fold stage. The latency from `in_valid` to `out_valid` is then 1 cycle, or 0 when the register is left out. The default uses the register.

Top module: `csum_compress`

## Requirements
- R1: For any input set, `out_sum` equals the value obtained by starting from 0x0000 and adding the 32 words one at a time, where each 17-bit partial sum becomes its low 16 bits plus its bit 16. Word i sits at `in_words[16*i+15 : 16*i]`.
- R2: When every input word is 0x0000, `out_sum` is 0x0000.
- R3: When the true sum is a nonzero multiple of 0xFFFF (for example all words 0xFFFF), `out_sum` is 0xFFFF and is never 0x0000. More generally, any input set with at least one nonzero bit gives a nonzero `out_sum`.
- R4: When exactly one word is nonzero, `out_sum` equals that word, whatever its position.
- R5: With `PIPE` = 1, `out_valid` in a cycle equals `in_valid` of the previous cycle. With `PIPE` = 0, `out_valid` follows `in_valid` in the same cycle.
- R6: With `PIPE` = 1, `out_sum` keeps its value in the cycle after a cycle in which `in_valid` was low, however `in_words` changes.
- R7: With `PIPE` = 1, while `rst_n` is low and right after it is released, `out_valid` is 0 and `out_sum` is 0x0000.
- R8: Words whose ones pile up in the high columns, such as all words 0x8000, carry beyond bit 15 more than once. They still give the R1 result (all 0x8000 gives 0x0010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The word set on `in_words` is to be summed |
| in_words | input | 512 | 32 words of 16 bits, word i at bits 16*i+15 : 16*i |
| out_valid | output | 1 | `out_sum` holds a new result |
| out_sum | output | 16 | Ones' complement sum of the 32 words |

## Verification
The clocked properties assume that `in_words` is stable around the rising edge whenever `in_valid` is high, so that the captured total belongs to the word set seen by the checker. The bench changes `in_words` and `in_valid` only on falling edges. It also randomises `in_words` during idle cycles, so the hold property is tested against moving inputs rather than quiet ones. The zero and nonzero properties take `in_words` at the edge where `in_valid` is high as the set that produces the next result. Each transfer in the bench is a single-cycle pulse that keeps to this.

// File: rtl/csum_compress.sv
module csum_compress #(
  parameter int N    = 32,
  parameter int W    = 16,
  parameter bit PIPE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_words,
  output logic           out_valid,
  output logic [W-1:0]   out_sum
);

  function automatic int csa_levels(int n);
    int c = n;
    int l = 0;
    while (c > 2) begin
      c = c - c / 3;
      l++;
    end
    return l;
  endfunction

  localparam int SW     = W + $clog2(N);
  localparam int LEVELS = csa_levels(N);

  logic [SW-1:0] dots [N+2];
  logic [SW-1:0] next [N+2];
  logic [SW-1:0] total, total_q;

  always_comb begin : tree
    int cnt;
    int k;
    for (int i = 0; i < N + 2; i++) begin
      dots[i] = (i < N) ? SW'(in_words[i*W +: W]) : '0;
      next[i] = '0;
    end
    cnt = N;
    for (int lv = 0; lv < LEVELS; lv++) begin
      k = 0;
      for (int i = 0; i < N + 2; i++) next[i] = '0;
      for (int j = 0; j < N; j += 3) begin
        if (j + 2 < cnt) begin
          next[k]   = dots[j] ^ dots[j+1] ^ dots[j+2];
          next[k+1] = ((dots[j] & dots[j+1]) | (dots[j] & dots[j+2]) |
                       (dots[j+1] & dots[j+2])) << 1;
          k += 2;
        end else begin
          if (j < cnt) begin
            next[k] = dots[j];
            k++;
          end
          if (j + 1 < cnt) begin
            next[k] = dots[j+1];
            k++;
          end
        end
      end
      cnt = k;
      for (int i = 0; i < N + 2; i++) dots[i] = next[i];
    end
  end

  assign total = dots[0] + dots[1];

  generate
    if (PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          total_q   <= '0;
          out_valid <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) total_q <= total;
        end
      end
    end else begin : g_comb
      assign total_q   = total;
      assign out_valid = in_valid;
    end
  endgenerate

  logic [W:0] fold1;
  logic [W:0] fold2;
  assign fold1   = {1'b0, total_q[W-1:0]} + (W+1)'(total_q[SW-1:W]);
  assign fold2   = {1'b0, fold1[W-1:0]} + (W+1)'(fold1[W]);
  assign out_sum = fold2[W-1:0];

endmodule

// File: rtl/csum_compress_chk.sv
module csum_compress_chk #(
  parameter int N    = 32,
  parameter int W    = 16,
  parameter bit PIPE = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N*W-1:0] in_words,
  input logic           out_valid,
  input logic [W-1:0]   out_sum
);

  generate
    if (PIPE) begin : g_reg
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);  // R5
      AST_IDLE_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R5
      AST_SUM_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_sum)); // R6
      AST_ZERO_IN:       assert property (@(posedge clk) disable iff (!rst_n)
                           (in_valid && in_words == '0) |=> out_sum == '0);  // R2
      AST_NONZERO_IN:    assert property (@(posedge clk) disable iff (!rst_n)
                           (in_valid && in_words != '0) |=> out_sum != '0);  // R3
      AST_RESET_CLEAR:   assert property (@(posedge clk)
                           !rst_n |=> (!out_valid && out_sum == '0));        // R7
    end else begin : g_comb
      AST_VALID_SAME:    assert property (@(posedge clk) disable iff (!rst_n) out_valid == in_valid); // R5
      AST_ZERO_IN:       assert property (@(posedge clk) disable iff (!rst_n)
                           (in_valid && in_words == '0) |-> out_sum == '0);  // R2
      AST_NONZERO_IN:    assert property (@(posedge clk) disable iff (!rst_n)
                           (in_valid && in_words != '0) |-> out_sum != '0);  // R3
      AST_SUM_FINITE:    assert property (@(posedge clk) disable iff (!rst_n)
                           !$isunknown(out_sum));                            // R1
    end
  endgenerate

endmodule

bind csum_compress csum_compress_chk #(.N(N), .W(W), .PIPE(PIPE)) u_chk (.*);

// File: tb/csum_compress_bench.sv
module csum_compress_bench;
  localparam int N = 32;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_words = '0;
  logic           out_valid;
  logic [W-1:0]   out_sum;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csum_compress #(.N(N), .W(W), .PIPE(1'b1)) u_csum_compress (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic logic [W-1:0] ref_sum(logic [N*W-1:0] v);
    logic [W:0] acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = {1'b0, acc[W-1:0]} + {1'b0, v[i*W +: W]};
      acc = {1'b0, acc[W-1:0]} + (W+1)'(acc[W]);
    end
    return acc[W-1:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [N*W-1:0] v, string req);
    logic [W-1:0] exp = ref_sum(v);
    logic [W-1:0] held;
    @(negedge clk);
    in_valid = 1'b1;
    in_words = v;
    @(negedge clk);
    check("R5 valid", 32'(out_valid), 32'd1);
    check(req, 32'(out_sum), 32'(exp));
    held = out_sum;
    in_valid = 1'b0;
    for (int i = 0; i < N; i++) in_words[i*W +: W] = W'($urandom);
    @(negedge clk);
    check("R5 idle", 32'(out_valid), 32'd0);
    check("R6 hold", 32'(out_sum), 32'(held));
  endtask

  initial begin
    logic [N*W-1:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R7 valid", 32'(out_valid), 32'd0);
    check("R7 sum", 32'(out_sum), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release", 32'(out_sum), 32'd0);

    apply('0, "R2 all zero");
    check("R2 expected", 32'(ref_sum('0)), 32'h0);
    apply({N*W{1'b1}}, "R3 all ones");
    check("R3 expected", 32'(ref_sum({N*W{1'b1}})), 32'hFFFF);
    v = '0;
    v[0 +: W] = 16'hFFFF;
    apply(v, "R3 single FFFF");
    v = '0;
    v[5*W +: W] = 16'hA5C3;
    apply(v, "R4 single word");
    check("R4 expected", 32'(ref_sum(v)), 32'hA5C3);
    v = '0;
    v[(N-1)*W +: W] = 16'h0001;
    apply(v, "R4 last word");
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'h8000;
    apply(v, "R8 all 8000");
    check("R8 expected", 32'(ref_sum(v)), 32'h0010);
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'hFFFE;
    apply(v, "R8 all FFFE");
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      if (t % 4 == 1) for (int i = 0; i < N; i++) v[i*W +: W] |= 16'hF000;
      apply(v, "R1 random");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule